// File: doc/BRIEF.md
# Feed-Locked Countdown Watchdog

This block is a watchdog timer on a simple register bus with 32-bit data and word offsets. Software programs a reload value, sets a sticky enable and then proves it is alive by writing a two-word key to a feed register. The first good key after the enable arms the block. From then on a 24-bit counter counts down once every fourth clock. If it reaches zero, or if software writes a broken key, the block raises a reset request that stays high until the block is itself reset. The bus clock and the counting clock are one domain.

Four word registers are decoded. A control register holds the enable, the reset-on-timeout select and a read-only timeout flag. A load register holds the reload value. A write-only feed register accepts the key. A read-only register returns the live count. Once armed, the block cannot be stopped: the enable ignores writes of zero, and any bus access that breaks up a key is treated as a fault.

Top module: `wdt_feedlock`

## Requirements
- R1: After rst_ni is released, the control register reads 0, the load register and the count register read 0x0000_00FF, and reset_req_o is low.
- R2: Offsets: control at 0x0 (bit 0 enable, bit 1 reset select, bit 2 timeout flag, read-only), load at 0x4, feed at 0x8 (reads 0), count at 0xC (returns the 24-bit count zero-extended, and writes to it are ignored). Reads are combinational from addr_i.
- R3: A write to the load register keeps only bits 23:0. A value below 0xFF is stored as 0xFF.
- R4: The enable bit is set by writing 1 to control bit 0 and cannot be cleared by software. The reset select bit follows every control write.
- R5: A valid feed is a feed-register write of 0x0000_00AA followed by a feed-register write of 0x0000_0055. Idle bus cycles may come between the two writes. With the enable set, the feed loads the count from the load register, clears the prescaler and arms the watchdog.
- R6: While the enable is clear, feed writes of any value do not change the count and do not arm the watchdog.
- R7: Setting the enable alone does not start the count.
- R8: k clock edges after the edge that completes a valid feed, the count equals load − floor(k/4). No later feed takes place before that point.
- R9: When the count reaches 0, it stays at 0 and the timeout flag is set. If the reset select is set, reset_req_o rises on that same edge and stays high until rst_ni.
- R10: With the reset select clear, expiry sets the timeout flag but does not raise reset_req_o.
- R11: While armed, a 0xAA feed write followed by a feed write of any other value leaves the count unloaded. If the reset select is set, this raises reset_req_o on the edge that takes the second write.
- R12: While armed, any bus access between the 0xAA and the 0x55 other than a feed write counts as a broken feed in the same way as R11. The access itself still takes effect.
- R13: A broken feed before the watchdog is armed does not raise reset_req_o.
- R14: A valid feed while armed reloads the count from the current load value and restarts the prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the bus and the counter |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Bus access valid |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | 4 | Byte offset of the word register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| reset_req_o | output | 1 | Sticky system reset request |

## Verification
A prescaler that is off by one, or one that is not cleared on a reload, shows at the count register within four clocks of a feed. The bench therefore samples the count on every edge after a feed. A feed-sequence state that is lost or kept too long can show up in two ways: as a count that was not reloaded, or as reset_req_o rising on the edge of the second key write or on the edge of an intervening access. Because the request is sticky, a false trip is still visible at any later sample. An expiry decoded one count early or late moves the reset_req_o edge by four clocks, so the bench checks the edge just before zero and the edge at zero.

// File: rtl/wdt_feedlock_pkg.sv
package wdt_feedlock_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 4;

  localparam logic [ADDR_W-1:0] OFS_CTRL  = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_LOAD  = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_FEED  = 4'h8;
  localparam logic [ADDR_W-1:0] OFS_COUNT = 4'hC;

  localparam logic [DATA_W-1:0] KEY_OPEN  = 32'h0000_00AA;
  localparam logic [DATA_W-1:0] KEY_CLOSE = 32'h0000_0055;

  localparam int unsigned CTRL_EN_BIT   = 0;
  localparam int unsigned CTRL_RST_BIT  = 1;
  localparam int unsigned CTRL_FLAG_BIT = 2;

  typedef enum logic {
    FEED_IDLE,
    FEED_OPEN
  } feed_state_e;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_feedlock_pkg::*;
#(
  parameter int unsigned CNT_W    = 24,
  parameter int unsigned LOAD_MIN = 255
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              flag_i,
  output logic              en_o,
  output logic              rst_sel_o,
  output logic [CNT_W-1:0]  load_o,
  output logic              feed_wr_o,
  output logic              other_acc_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam logic [CNT_W-1:0] LOAD_FLOOR = CNT_W'(LOAD_MIN);

  logic             en_q, rst_sel_q;
  logic [CNT_W-1:0] load_q;
  logic             wr, hit_ctrl, hit_load, hit_feed;

  assign wr       = req_i & we_i;
  assign hit_ctrl = (addr_i == OFS_CTRL);
  assign hit_load = (addr_i == OFS_LOAD);
  assign hit_feed = (addr_i == OFS_FEED);

  assign feed_wr_o   = wr & hit_feed;
  assign other_acc_o = req_i & ~(we_i & hit_feed);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q      <= 1'b0;
      rst_sel_q <= 1'b0;
      load_q    <= LOAD_FLOOR;
    end else if (wr) begin
      if (hit_ctrl) begin
        en_q      <= en_q | wdata_i[CTRL_EN_BIT];  // set-only
        rst_sel_q <= wdata_i[CTRL_RST_BIT];
      end
      if (hit_load) load_q <= (wdata_i < LOAD_FLOOR) ? LOAD_FLOOR : wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFS_CTRL: begin
        rdata_o[CTRL_EN_BIT]   = en_q;
        rdata_o[CTRL_RST_BIT]  = rst_sel_q;
        rdata_o[CTRL_FLAG_BIT] = flag_i;
      end
      OFS_LOAD:  rdata_o = DATA_W'(load_q);
      OFS_COUNT: rdata_o = DATA_W'(count_i);
      default:   rdata_o = '0;
    endcase
  end

  assign en_o      = en_q;
  assign rst_sel_o = rst_sel_q;
  assign load_o    = load_q;

  assert_enable_sticky_R4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q |=> en_q);
  assert_load_floor_R3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_q >= LOAD_FLOOR);
endmodule

// File: rtl/wdt_feed_seq.sv
module wdt_feed_seq
  import wdt_feedlock_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              feed_wr_i,
  input  logic              other_acc_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              feed_ok_o,
  output logic              feed_bad_o
);
  feed_state_e state_q, state_d;

  always_comb begin
    state_d    = state_q;
    feed_ok_o  = 1'b0;
    feed_bad_o = 1'b0;
    unique case (state_q)
      FEED_IDLE: if (feed_wr_i && wdata_i == KEY_OPEN) state_d = FEED_OPEN;
      FEED_OPEN: begin
        if (feed_wr_i) begin
          state_d = FEED_IDLE;
          if (wdata_i == KEY_CLOSE) feed_ok_o = 1'b1;
          else                      feed_bad_o = 1'b1;
        end else if (other_acc_i) begin
          state_d    = FEED_IDLE;  // split key
          feed_bad_o = 1'b1;
        end
      end
      default: state_d = FEED_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= FEED_IDLE;
    else         state_q <= state_d;
  end

  assert_feed_exclusive_R11 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({feed_ok_o, feed_bad_o}));
  assert_close_needs_open_R5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (feed_ok_o || feed_bad_o) |=> state_q == FEED_IDLE);
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
  parameter int unsigned CNT_W    = 24,
  parameter int unsigned PRESCALE = 4,
  parameter int unsigned LOAD_MIN = 255
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             feed_ok_i,
  input  logic [CNT_W-1:0] load_i,
  output logic [CNT_W-1:0] count_o,
  output logic             armed_o,
  output logic             expire_o,
  output logic             flag_o
);
  localparam int unsigned PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

  logic [CNT_W-1:0] count_q;
  logic [PRE_W-1:0] pre_q;
  logic             armed_q, flag_q, tick, reload;

  assign reload = feed_ok_i & en_i;

  generate
    if (PRESCALE > 1) begin : g_div
      assign tick = armed_q && (pre_q == PRE_LAST) && (count_q != '0);
    end else begin : g_nodiv
      assign tick = armed_q && (count_q != '0);
    end
  endgenerate

  assign expire_o = tick && (count_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= CNT_W'(LOAD_MIN);
      pre_q   <= '0;
      armed_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      if (reload) begin
        armed_q <= 1'b1;
        count_q <= load_i;
        pre_q   <= '0;
      end else if (armed_q) begin
        pre_q <= (pre_q == PRE_LAST) ? '0 : pre_q + 1'b1;
        if (tick) count_q <= count_q - 1'b1;
      end
      if (expire_o) flag_q <= 1'b1;
    end
  end

  assign count_o = count_q;
  assign armed_o = armed_q;
  assign flag_o  = flag_q;

  assert_armed_needs_enable_R7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |-> en_i);
  assert_count_holds_R8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!feed_ok_i && (!armed_q || pre_q != PRE_LAST)) |=> $stable(count_q));
  assert_count_steps_R8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!feed_ok_i && armed_q && pre_q == PRE_LAST && count_q != '0)
      |=> count_q == $past(count_q) - 1'b1);
  assert_zero_parks_R9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!feed_ok_i && count_q == '0) |=> count_q == '0);
  assert_flag_sticky_R9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q |=> flag_q);
endmodule

// File: rtl/wdt_feedlock.sv
module wdt_feedlock
  import wdt_feedlock_pkg::*;
#(
  parameter int unsigned CNT_W    = 24,
  parameter int unsigned PRESCALE = 4,
  parameter int unsigned LOAD_MIN = 255
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              reset_req_o
);
  logic             en, rst_sel, feed_wr, other_acc, feed_ok, feed_bad;
  logic             armed, expire, flag, trip, reset_q;
  logic [CNT_W-1:0] load, count;

  wdt_regs #(.CNT_W(CNT_W), .LOAD_MIN(LOAD_MIN)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i,
    .wdata_i    (wdata_i[CNT_W-1:0]),
    .count_i    (count),
    .flag_i     (flag),
    .en_o       (en),
    .rst_sel_o  (rst_sel),
    .load_o     (load),
    .feed_wr_o  (feed_wr),
    .other_acc_o(other_acc),
    .rdata_o
  );

  wdt_feed_seq u_feed (
    .clk_i, .rst_ni,
    .feed_wr_i  (feed_wr),
    .other_acc_i(other_acc),
    .wdata_i,
    .feed_ok_o  (feed_ok),
    .feed_bad_o (feed_bad)
  );

  wdt_countdown #(.CNT_W(CNT_W), .PRESCALE(PRESCALE), .LOAD_MIN(LOAD_MIN)) u_cnt (
    .clk_i, .rst_ni,
    .en_i     (en),
    .feed_ok_i(feed_ok),
    .load_i   (load),
    .count_o  (count),
    .armed_o  (armed),
    .expire_o (expire),
    .flag_o   (flag)
  );

  assign trip = rst_sel & (expire | (feed_bad & armed));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) reset_q <= 1'b0;
    else         reset_q <= reset_q | trip;
  end

  assign reset_req_o = reset_q;

  assert_reset_sticky_R9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_req_o |=> reset_req_o);
  assert_expiry_trips_R9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_sel && expire) |=> reset_req_o);
  assert_bad_feed_trips_R11 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_sel && armed && feed_bad) |=> reset_req_o);
  assert_unarmed_no_trip_R13 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reset_req_o && !armed) |=> !reset_req_o);
  assert_no_select_no_trip_R10 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reset_req_o && !rst_sel) |=> !reset_req_o);
endmodule

// File: tb/wdt_feedlock_bench.sv
module wdt_feedlock_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [3:0]  addr = 4'h0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rreq;
  int checks = 0, errors = 0;

  localparam logic [3:0] A_CTRL = 4'h0, A_LOAD = 4'h4, A_FEED = 4'h8, A_CNT = 4'hC;

  always #10 clk = ~clk;

  wdt_feedlock u_wdt_feedlock (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .reset_req_o(rreq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; req = 1'b0; we = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk); req = 1'b0;
  endtask

  task automatic peek(input logic [3:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic feed();
    wr(A_FEED, 32'hAA); wr(A_FEED, 32'h55);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [31:0] loads [7];
    logic [31:0] bads [5];
    loads = '{32'h0, 32'h1, 32'hFE, 32'hFF, 32'h100, 32'hFFFF_FFFF, 32'h1234_5678};
    bads  = '{32'h0, 32'hAA, 32'h54, 32'h56, 32'h155};

    do_reset();
    // R1 reset state
    peek(A_CTRL, v); chk("R1 ctrl", v, 0);
    peek(A_LOAD, v); chk("R1 load", v, 32'hFF);
    peek(A_CNT, v);  chk("R1 count", v, 32'hFF);
    chk("R1 reset_req", {31'b0, rreq}, 0);

    // R3 load clamp and masking
    foreach (loads[i]) begin
      logic [31:0] e;
      e = {8'h0, loads[i][23:0]};
      if (e < 32'hFF) e = 32'hFF;
      wr(A_LOAD, loads[i]);
      peek(A_LOAD, v); chk("R3 load write", v, e);
    end
    // R2 count read-only, feed reads zero
    wr(A_CNT, 32'h1234);
    peek(A_CNT, v);  chk("R2 count write ignored", v, 32'hFF);
    peek(A_FEED, v); chk("R2 feed reads zero", v, 0);

    // R6 feeds while disabled
    wr(A_FEED, 32'h55); feed();
    repeat (20) @(negedge clk);
    peek(A_CNT, v); chk("R6 disabled feed", v, 32'hFF);
    // R13 broken feed before arming
    wr(A_CTRL, 32'h2);
    wr(A_FEED, 32'hAA); wr(A_FEED, 32'h11);
    chk("R13 unarmed bad feed", {31'b0, rreq}, 0);
    // R7 enable alone
    wr(A_CTRL, 32'h3);
    repeat (12) @(negedge clk);
    peek(A_CNT, v); chk("R7 enable only", v, 32'hFF);
    // R4 sticky enable
    wr(A_CTRL, 32'h0);
    peek(A_CTRL, v); chk("R4 clear ignored", v, 32'h1);
    wr(A_CTRL, 32'h3);
    peek(A_CTRL, v); chk("R4 select set", v, 32'h3);

    // R5 and R8 feed then prescaled sweep
    wr(A_LOAD, 32'h100);
    feed();
    for (int k = 0; k <= 40; k++) begin
      if (k > 0) @(negedge clk);
      peek(A_CNT, v); chk("R8 prescale sweep", v, 32'h100 - k / 4);
    end
    chk("R5 no trip on good feed", {31'b0, rreq}, 0);

    // R14 refeed with new load
    wr(A_LOAD, 32'h300);
    feed();
    peek(A_CNT, v); chk("R14 reload", v, 32'h300);
    repeat (3) @(negedge clk);
    peek(A_CNT, v); chk("R14 prescaler restart k3", v, 32'h300);
    @(negedge clk);
    peek(A_CNT, v); chk("R14 prescaler restart k4", v, 32'h2FF);

    // R12 write to another register splits the key
    wr(A_FEED, 32'hAA);
    wr(A_LOAD, 32'h200);
    chk("R12 split by write trips", {31'b0, rreq}, 1);
    peek(A_LOAD, v); chk("R12 access takes effect", v, 32'h200);
    peek(A_CNT, v);  checks++;
    if (v == 32'h200 || v > 32'h2FF) begin
      errors++; $display("FAIL R12 count reloaded actual=%h expected<=%h not 200", v, 32'h2FF);
    end

    // R11 broken second key sweep
    foreach (bads[i]) begin
      do_reset();
      wr(A_CTRL, 32'h3); feed();
      wr(A_FEED, 32'hAA);
      chk("R11 before second key", {31'b0, rreq}, 0);
      wr(A_FEED, bads[i]);
      chk("R11 bad second key", {31'b0, rreq}, 1);
    end

    // R12 read access splits the key
    do_reset();
    wr(A_CTRL, 32'h3); feed();
    wr(A_FEED, 32'hAA);
    rd(A_CTRL);
    chk("R12 split by read trips", {31'b0, rreq}, 1);

    // R9 expiry with reset select
    do_reset();
    wr(A_CTRL, 32'h3); feed();
    repeat (1019) @(negedge clk);
    peek(A_CNT, v); chk("R9 count before zero", v, 1);
    chk("R9 no request before zero", {31'b0, rreq}, 0);
    @(negedge clk);
    peek(A_CNT, v); chk("R9 count zero", v, 0);
    chk("R9 request at zero", {31'b0, rreq}, 1);
    peek(A_CTRL, v); chk("R9 flag", v, 32'h7);
    repeat (10) @(negedge clk);
    peek(A_CNT, v); chk("R9 count parked", v, 0);
    chk("R9 request held", {31'b0, rreq}, 1);
    do_reset();
    chk("R1 request cleared by reset", {31'b0, rreq}, 0);

    // R10 expiry without reset select
    wr(A_CTRL, 32'h1); feed();
    repeat (1020) @(negedge clk);
    peek(A_CNT, v);  chk("R10 count zero", v, 0);
    peek(A_CTRL, v); chk("R10 flag only", v, 32'h5);
    chk("R10 no request", {31'b0, rreq}, 0);
    wr(A_FEED, 32'hAA); wr(A_FEED, 32'h99);
    chk("R10 bad feed no select", {31'b0, rreq}, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule